// File: doc/BRIEF.md
# Programmable Bit-Slice Arithmetic and Logic Unit

This block is an N-bit arithmetic and logic unit (8 bits by default) assembled from identical one-bit slices. Each slice holds three generic two-input function units and one fixed carry cell. A generic function unit is a 4-to-1 multiplexer. Its two data bits drive the select lines, and a 4-bit truth-table code feeds the multiplexer's data inputs. Any Boolean function of two inputs is therefore available by choosing the code.

In each slice, a propagate unit and a kill unit work on the operand bits. A result unit then combines the propagate bit with the incoming carry. The carry cell forms the next carry from the propagate and kill terms. The same cell serves as the borrow chain during subtraction, because subtraction only loads different codes.

A small decoder turns a 4-bit operation select into the three truth-table codes and the carry-in of bit 0. The supported operations are pass, AND, OR, XOR, add, add with carry, increment, subtract and subtract with borrow. The block is purely combinational: the result word and the carry/borrow out follow the inputs in the same cycle.

Top module: `slice_alu`

## Requirements
- R1: With `op` = 0 (pass), `y` equals `a` and `cout` is 0.
- R2: With `op` = 1, 2 or 3, `y` is `a & b`, `a | b` or `a ^ b` respectively, and `cout` is 0.
- R3: With `op` = 4 (add), `{cout, y}` equals `a + b`. `cin` has no effect.
- R4: With `op` = 5 (add with carry), `{cout, y}` equals `a + b + cin`.
- R5: With `op` = 6 (increment), `y` equals `a + 1` modulo 2^N. `cout` is 1 exactly when `a` is all ones. Neither `b` nor `cin` has any effect.
- R6: With `op` = 7 (subtract), `y` equals `a - b` modulo 2^N. `cout` is the borrow, 1 exactly when `a < b`. `cin` has no effect.
- R7: With `op` = 8 (subtract with borrow), `y` equals `a - b - cin` modulo 2^N. `cout` is 1 exactly when `a < b + cin`.
- R8: Operation codes 9 to 15 behave as pass: `y` equals `a` and `cout` is 0.
- R9: The block holds no state. A new `op`, `a`, `b` or `cin` is reflected on `y` and `cout` in the same cycle, whatever the previous inputs were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op   | input  | 4 | Operation select (codes as in R1 to R8) |
| a    | input  | N | First operand |
| b    | input  | N | Second operand |
| cin  | input  | 1 | External carry-in (add with carry) or borrow-in (subtract with borrow) |
| y    | output | N | Result word |
| cout | output | 1 | Carry out of the top slice for addition and increment, borrow out for subtraction, 0 for logic operations |

## Verification
The carry ripple through every slice and the carry-out of the top slice resolve together in one evaluation. The same chain also carries the borrow when subtraction codes are loaded. Both are provoked with operands that ripple the full width: all-ones plus one, zero minus one, and zero minus zero with a borrow-in. The result word and `cout` are then judged as one (N+1)-bit value against the arithmetic reference. Random back-to-back changes of operation between carry and borrow forms show that no stale chain value survives from the previous operation.

// File: rtl/slice_alu_pkg.sv
// Package: shared truth-table codes, operation selects and the control record
// that the operation decoder hands to the slice array.
// Assumes: a truth-table code is indexed as code[{x, y}], x the upper select bit.
package slice_alu_pkg;

    localparam int OP_W = 4;
    localparam int TT_W = 4;

    typedef logic [TT_W-1:0] tt_code_t;
    typedef logic [OP_W-1:0] op_sel_t;

    // Truth-table codes under code[{x,y}] indexing
    localparam tt_code_t TT_ZERO   = 4'd0;
    localparam tt_code_t TT_NOR    = 4'd1;
    localparam tt_code_t TT_NOT_X  = 4'd3;
    localparam tt_code_t TT_X_NY   = 4'd4;   // x and not y
    localparam tt_code_t TT_XOR    = 4'd6;
    localparam tt_code_t TT_AND    = 4'd8;
    localparam tt_code_t TT_XNOR   = 4'd9;
    localparam tt_code_t TT_PASS_X = 4'd12;
    localparam tt_code_t TT_OR     = 4'd14;

    // Operation selects
    localparam op_sel_t OP_PASS = 4'd0;
    localparam op_sel_t OP_AND  = 4'd1;
    localparam op_sel_t OP_OR   = 4'd2;
    localparam op_sel_t OP_XOR  = 4'd3;
    localparam op_sel_t OP_ADD  = 4'd4;
    localparam op_sel_t OP_ADC  = 4'd5;
    localparam op_sel_t OP_INC  = 4'd6;
    localparam op_sel_t OP_SUB  = 4'd7;
    localparam op_sel_t OP_SBB  = 4'd8;

    typedef struct packed {
        tt_code_t p_code;    // propagate unit function of (a_i, b_i)
        tt_code_t k_code;    // kill unit function of (a_i, b_i)
        tt_code_t r_code;    // result unit function of (p_i, c_i)
        logic     c0;        // carry/borrow into slice 0
        logic     is_logic;  // carry chain output is not meaningful
    } slice_ctrl_t;

endpackage

// File: rtl/tt_fn_unit.sv
// Generic two-input function unit: a 4-to-1 multiplexer whose select lines
// are the data bits and whose data inputs are a truth-table code.
// Assumes: code bit index is {x, y}, x most significant.
module tt_fn_unit
    import slice_alu_pkg::*;
(
    input  tt_code_t code,
    input  logic     x,
    input  logic     y,
    output logic     f
);

    // Select the code bit addressed by the data inputs
    always_comb begin
        f = code[{x, y}];
    end

endmodule

// File: rtl/pk_carry_cell.sv
// Dedicated carry cell: next carry = p*c + p'*k'. The same cell serves as the
// borrow cell when the subtract codes are loaded into the P and K units.
// Assumes: p and k come from the same slice's function units.
module pk_carry_cell (
    input  logic p,
    input  logic k,
    input  logic c_in,
    output logic c_out
);

    // Propagate the incoming carry, or generate from the kill term
    always_comb begin
        c_out = (p & c_in) | (~p & ~k);
    end

    // Chain behaviour seen from the neighbouring slices
    always_comb begin
        // R3
        if (!$isunknown({p, c_in}) && p) begin
            prop_pass_chk: assert (c_out == c_in)
                else $error("carry cell: propagate did not pass carry");
        end
        // R6
        if (!$isunknown({p, k}) && !p && k) begin
            kill_chk: assert (c_out == 1'b0)
                else $error("carry cell: kill did not clear carry");
        end
    end

endmodule

// File: rtl/alu_bit_slice.sv
// One bit slice: propagate unit and kill unit on (a_i, b_i), result unit on
// (p_i, c_i), and a carry cell producing c_(i+1).
// Assumes: all slices share the same three codes from the decoder.
module alu_bit_slice
    import slice_alu_pkg::*;
(
    input  tt_code_t p_code,
    input  tt_code_t k_code,
    input  tt_code_t r_code,
    input  logic     a_i,
    input  logic     b_i,
    input  logic     c_i,
    output logic     r_i,
    output logic     c_o
);

    logic p_i;
    logic k_i;

    tt_fn_unit u_p_unit (
        .code (p_code),
        .x    (a_i),
        .y    (b_i),
        .f    (p_i)
    );

    tt_fn_unit u_k_unit (
        .code (k_code),
        .x    (a_i),
        .y    (b_i),
        .f    (k_i)
    );

    tt_fn_unit u_r_unit (
        .code (r_code),
        .x    (p_i),
        .y    (c_i),
        .f    (r_i)
    );

    pk_carry_cell u_carry (
        .p     (p_i),
        .k     (k_i),
        .c_in  (c_i),
        .c_out (c_o)
    );

endmodule

// File: rtl/alu_op_decoder.sv
// Operation decoder: maps an operation select and the external carry/borrow
// to the propagate, kill and result codes and to the carry into slice 0.
// Assumes: unlisted selects fall back to pass, with the chain output unused.
module alu_op_decoder
    import slice_alu_pkg::*;
(
    input  op_sel_t     op,
    input  logic        cin,
    output slice_ctrl_t ctrl
);

    // Choose the codes for each operation
    always_comb begin
        ctrl = '{p_code: TT_PASS_X, k_code: TT_ZERO, r_code: TT_PASS_X,
                 c0: 1'b0, is_logic: 1'b1};
        unique case (op)
            OP_AND: ctrl.p_code = TT_AND;
            OP_OR:  ctrl.p_code = TT_OR;
            OP_XOR: ctrl.p_code = TT_XOR;
            OP_ADD, OP_ADC: begin
                ctrl.p_code   = TT_XOR;
                ctrl.k_code   = TT_NOR;
                ctrl.r_code   = TT_XOR;
                ctrl.c0       = (op == OP_ADC) ? cin : 1'b0;
                ctrl.is_logic = 1'b0;
            end
            OP_INC: begin
                ctrl.p_code   = TT_PASS_X;
                ctrl.k_code   = TT_NOT_X;
                ctrl.r_code   = TT_XOR;
                ctrl.c0       = 1'b1;
                ctrl.is_logic = 1'b0;
            end
            OP_SUB, OP_SBB: begin
                ctrl.p_code   = TT_XNOR;
                ctrl.k_code   = TT_X_NY;
                ctrl.r_code   = TT_XNOR;
                ctrl.c0       = (op == OP_SBB) ? cin : 1'b0;
                ctrl.is_logic = 1'b0;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/slice_alu.sv
// Top: N identical bit slices chained through their carry cells, steered by
// the operation decoder. Purely combinational.
// Assumes: cout is forced to 0 for every logic or pass operation.
module slice_alu
    import slice_alu_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [OP_W-1:0] op,
    input  logic [N-1:0]    a,
    input  logic [N-1:0]    b,
    input  logic            cin,
    output logic [N-1:0]    y,
    output logic            cout
);

    localparam int CHAIN_W = N + 1;

    slice_ctrl_t        ctrl;
    logic [CHAIN_W-1:0] chain;

    alu_op_decoder u_dec (
        .op   (op),
        .cin  (cin),
        .ctrl (ctrl)
    );

    // Carry into the bottom slice comes from the decoder
    always_comb begin
        chain[0] = ctrl.c0;
    end

    for (genvar i = 0; i < N; i++) begin : g_slice
        alu_bit_slice u_slice (
            .p_code (ctrl.p_code),
            .k_code (ctrl.k_code),
            .r_code (ctrl.r_code),
            .a_i    (a[i]),
            .b_i    (b[i]),
            .c_i    (chain[i]),
            .r_i    (y[i]),
            .c_o    (chain[i+1])
        );
    end

    // Present the top carry/borrow, masked for logic operations
    always_comb begin
        cout = ctrl.is_logic ? 1'b0 : chain[N];
    end

    // Port-level checks against arithmetic reference values
    always_comb begin
        if (!$isunknown({op, a, b, cin})) begin
            // R2
            if (op <= OP_XOR || op > OP_SBB) begin
                logic_cout_chk: assert (cout == 1'b0)
                    else $error("cout not zero for logic op");
            end
            // R3
            if (op == OP_ADD) begin
                add_sum_chk: assert ({cout, y} == ({1'b0, a} + {1'b0, b}))
                    else $error("add mismatch");
            end
            // R5
            if (op == OP_INC) begin
                inc_chk: assert ({cout, y} == ({1'b0, a} + {{N{1'b0}}, 1'b1}))
                    else $error("increment mismatch");
            end
            // R6
            if (op == OP_SUB) begin
                sub_diff_chk: assert (y == N'(a - b) && cout == (a < b))
                    else $error("subtract mismatch");
            end
        end
    end

endmodule

// File: tb/slice_alu_tb.sv
// Bench: directed corner cases plus seeded random stimulus, checked against
// reference values computed from the requirements.
module slice_alu_tb;

    localparam int N       = 8;
    localparam int N_RAND  = 4000;
    localparam int WD_CYC  = 150000;

    logic         clk;
    logic         rst_n;
    logic [3:0]   op;
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic         cin;
    logic [N-1:0] y;
    logic         cout;

    int checks;
    int errors;
    bit done;

    slice_alu #(.N(N)) u_dut (
        .op   (op),
        .a    (a),
        .b    (b),
        .cin  (cin),
        .y    (y),
        .cout (cout)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Reference {cout, y} from the requirements
    function automatic logic [N:0] ref_val(input logic [3:0] o, input logic [N-1:0] x,
                                           input logic [N-1:0] z, input logic ci);
        logic [N:0] r;
        case (o)
            4'd1: r = {1'b0, x & z};
            4'd2: r = {1'b0, x | z};
            4'd3: r = {1'b0, x ^ z};
            4'd4: r = {1'b0, x} + {1'b0, z};
            4'd5: r = {1'b0, x} + {1'b0, z} + {{N{1'b0}}, ci};
            4'd6: r = {1'b0, x} + 1;
            4'd7: r = {(x < z), N'(x - z)};
            4'd8: r = {({1'b0, x} < ({1'b0, z} + {{N{1'b0}}, ci})), N'(x - z - {{(N-1){1'b0}}, ci})};
            default: r = {1'b0, x};
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1, 4'd2, 4'd3: return "R2";
            4'd4: return "R3";
            4'd5: return "R4";
            4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Drive on the falling edge, sample shortly after
    task automatic apply_check(input logic [3:0] o, input logic [N-1:0] x,
                               input logic [N-1:0] z, input logic ci, input string tag);
        logic [N:0] exp;
        @(negedge clk);
        op = o; a = x; b = z; cin = ci;
        #1;
        exp = ref_val(o, x, z, ci);
        checks++;
        if ({cout, y} !== exp) begin
            errors++;
            $display("FAIL %s op=%0d a=%0h b=%0h cin=%0b actual cout/y=%0b/%0h expected %0b/%0h",
                     tag, o, x, z, ci, cout, y, exp[N], exp[N-1:0]);
        end
    endtask

    initial begin
        checks = 0; errors = 0; done = 0;
        rst_n = 1'b0; op = '0; a = '0; b = '0; cin = 1'b0;
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // R1: idle state with zero inputs
        apply_check(4'd0, '0, '0, 1'b0, "R1 idle");
        apply_check(4'd0, 8'hA5, 8'h3C, 1'b1, "R1");
        // R2
        apply_check(4'd1, 8'hF0, 8'h3C, 1'b1, "R2 and");
        apply_check(4'd2, 8'hF0, 8'h0F, 1'b1, "R2 or");
        apply_check(4'd3, 8'hFF, 8'hFF, 1'b1, "R2 xor");
        // R3: full ripple, cin ignored
        apply_check(4'd4, 8'hFF, 8'h01, 1'b0, "R3 ripple");
        apply_check(4'd4, 8'hFF, 8'h01, 1'b1, "R3 cin ignored");
        apply_check(4'd4, 8'hFF, 8'hFF, 1'b1, "R3 max");
        // R4
        apply_check(4'd5, 8'hFF, 8'h00, 1'b1, "R4 ripple");
        apply_check(4'd5, 8'h7F, 8'h80, 1'b0, "R4");
        // R5
        apply_check(4'd6, 8'hFF, 8'h12, 1'b1, "R5 wrap");
        apply_check(4'd6, 8'h00, 8'hFF, 1'b0, "R5");
        apply_check(4'd6, 8'h7F, 8'h00, 1'b1, "R5 b/cin ignored");
        // R6
        apply_check(4'd7, 8'h00, 8'h01, 1'b0, "R6 max borrow");
        apply_check(4'd7, 8'h00, 8'h01, 1'b1, "R6 cin ignored");
        apply_check(4'd7, 8'h55, 8'h55, 1'b0, "R6 equal");
        apply_check(4'd7, 8'h00, 8'hFF, 1'b0, "R6");
        // R7
        apply_check(4'd8, 8'h00, 8'h00, 1'b1, "R7 borrow-in ripple");
        apply_check(4'd8, 8'h01, 8'h00, 1'b1, "R7 exact");
        apply_check(4'd8, 8'hFF, 8'hFF, 1'b1, "R7 all ones");
        // R8
        for (int o = 9; o < 16; o++) apply_check(4'(o), 8'hC3, 8'h5A, 1'b1, "R8");
        // R9: back-to-back carry and borrow forms with no stale state
        apply_check(4'd4, 8'hFF, 8'h01, 1'b0, "R9 add");
        apply_check(4'd7, 8'h00, 8'h01, 1'b0, "R9 sub next");
        apply_check(4'd2, 8'h00, 8'h00, 1'b0, "R9 logic next");
        // Random mix of every operation
        for (int i = 0; i < N_RAND; i++) begin
            logic [3:0] ro;
            ro = 4'($urandom_range(0, 15));
            apply_check(ro, N'($urandom), N'($urandom), 1'($urandom), req_of(ro));
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule